// File: doc/BRIEF.md
# Integer Execute Unit

This block is the execute stage of a 64-bit register machine. It is purely combinational. An upstream decoder supplies an 8-bit operation code, the values of two source registers and an immediate that is already sign-extended. In the same cycle the unit returns the value to be written to the destination register, together with a write-enable.

It covers five groups of operations:
- add, subtract, multiply, divide and remainder;
- bitwise logic, including NOR;
- signed less-than compare;
- logical shifts;
- loading an immediate into the upper half of a register.

Register and immediate forms are provided where the operation map defines both. The op codes are laid out sparsely, grouped by their high nibble.

Division and remainder by zero give a defined result and raise a flag. Any op code the unit does not execute raises an unhandled-op output and suppresses the write, so that a control unit can send that instruction elsewhere.

Top module: `exec_unit`

## Requirements
- R1: ADD (0x10) gives a+b, ADDI (0x11) gives a+imm and SUB (0x12) gives a-b. All three wrap modulo 2^64 and assert wr_en.
- R2: MULT (0x13) gives the low 64 bits of a*b.
- R3: DIV (0x14) gives the signed quotient a/b, truncated toward zero. MOD (0x15) gives the matching remainder, which takes the sign of a. When a is the most negative value and b is -1, the quotient is a and the remainder is 0.
- R4: When b is 0, DIV returns all ones and MOD returns a. In both cases div_zero is asserted. div_zero is low for every other op and operand pair.
- R5: AND 0x30, ANDI 0x31, OR 0x32, ORI 0x33, XOR 0x34 and NOR 0x35 give the bitwise result of a with b (or with imm for the immediate forms). NOR gives ~(a|b).
- R6: SLT (0x36) and SLTI (0x37) give 1 when a is less than b (or than imm) as a signed number, and 0 otherwise.
- R7: SLLI (0x40) and SRLI (0x41) shift a by imm[5:0]. SLL (0x42) and SRL (0x43) shift a by b[5:0]. Right shifts fill with zeros.
- R8: LUI (0x22) gives imm shifted left by 32 bits. The low 32 bits of the result are zero.
- R9: NOP (0x00) drives wr_en low, result 0 and bad_op low, whatever the operands are.
- R10: Any op code not listed in R1 to R9 drives wr_en low, result 0, div_zero low and bad_op high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 8 | Operation code |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm | input | 64 | Sign-extended immediate |
| result | output | 64 | Value for the destination register |
| wr_en | output | 1 | Destination write enable |
| div_zero | output | 1 | Divide or remainder by zero |
| bad_op | output | 1 | Op code not executed by this unit |

## Verification
The immediate assertions evaluate inside the same combinational process that forms the outputs. They therefore assume that op and the operands hold known, two-state values for the whole evaluation. They make no assumption about which op codes arrive.

The bench changes all inputs together once per clock, just after the rising edge. It compares the outputs at the falling edge, when the unit has settled. It never leaves an input undriven.

The stimulus deliberately includes:
- op codes inside the handled groups' nibbles that are themselves unused;
- divisors of zero alongside non-divide ops;
- shift amounts above 63, so that only the low six bits count.

// File: rtl/exec_unit.sv
module exec_unit #(
  parameter int DW = 64
) (
  input  logic [7:0]    op,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [DW-1:0] imm,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic          div_zero,
  output logic          bad_op
);
  localparam int SHW  = $clog2(DW);
  localparam int HALF = DW / 2;

  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_ADD  = 8'h10;
  localparam logic [7:0] OP_ADDI = 8'h11;
  localparam logic [7:0] OP_SUB  = 8'h12;
  localparam logic [7:0] OP_MUL  = 8'h13;
  localparam logic [7:0] OP_DIV  = 8'h14;
  localparam logic [7:0] OP_REM  = 8'h15;
  localparam logic [7:0] OP_LUI  = 8'h22;
  localparam logic [7:0] OP_AND  = 8'h30;
  localparam logic [7:0] OP_ANDI = 8'h31;
  localparam logic [7:0] OP_OR   = 8'h32;
  localparam logic [7:0] OP_ORI  = 8'h33;
  localparam logic [7:0] OP_XOR  = 8'h34;
  localparam logic [7:0] OP_NOR  = 8'h35;
  localparam logic [7:0] OP_SLT  = 8'h36;
  localparam logic [7:0] OP_SLTI = 8'h37;
  localparam logic [7:0] OP_SLLI = 8'h40;
  localparam logic [7:0] OP_SRLI = 8'h41;
  localparam logic [7:0] OP_SLL  = 8'h42;
  localparam logic [7:0] OP_SRL  = 8'h43;

  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic          b_zero, div_ovf;
  logic [DW-1:0] quot, rem;
  logic [SHW-1:0] sh_imm, sh_reg;

  assign b_zero  = (src_b == '0);
  assign div_ovf = (src_a == MOST_NEG) && (&src_b);
  assign sh_imm  = imm[SHW-1:0];
  assign sh_reg  = src_b[SHW-1:0];

  assign quot = b_zero  ? '1 :
                div_ovf ? src_a :
                DW'($signed(src_a) / $signed(src_b));
  assign rem  = b_zero  ? src_a :
                div_ovf ? '0 :
                DW'($signed(src_a) % $signed(src_b));

  always_comb begin
    result   = '0;
    wr_en    = 1'b1;
    div_zero = 1'b0;
    bad_op   = 1'b0;
    case (op)
      OP_NOP:  wr_en = 1'b0;
      OP_ADD:  result = src_a + src_b;
      OP_ADDI: result = src_a + imm;
      OP_SUB:  result = src_a - src_b;
      OP_MUL:  result = src_a * src_b;
      OP_DIV:  begin result = quot; div_zero = b_zero; end
      OP_REM:  begin result = rem;  div_zero = b_zero; end
      OP_LUI:  result = imm << HALF;
      OP_AND:  result = src_a & src_b;
      OP_ANDI: result = src_a & imm;
      OP_OR:   result = src_a | src_b;
      OP_ORI:  result = src_a | imm;
      OP_XOR:  result = src_a ^ src_b;
      OP_NOR:  result = ~(src_a | src_b);
      OP_SLT:  result = {{(DW-1){1'b0}}, $signed(src_a) < $signed(src_b)};
      OP_SLTI: result = {{(DW-1){1'b0}}, $signed(src_a) < $signed(imm)};
      OP_SLLI: result = src_a << sh_imm;
      OP_SRLI: result = src_a >> sh_imm;
      OP_SLL:  result = src_a << sh_reg;
      OP_SRL:  result = src_a >> sh_reg;
      default: begin wr_en = 1'b0; bad_op = 1'b1; end
    endcase

    p_unhandled_quiet_r10: assert (!bad_op || (!wr_en && result == '0 && !div_zero))
      else $error("unhandled op wrote or flagged");
    p_nop_quiet_r9: assert (op != OP_NOP || (!wr_en && !bad_op && result == '0))
      else $error("nop not silent");
    p_dz_source_r4: assert (!div_zero || ((op == OP_DIV || op == OP_REM) && src_b == '0))
      else $error("div_zero without zero divisor");
    p_dz_quot_r4: assert (!(div_zero && op == OP_DIV) || (&result))
      else $error("zero-divide quotient not all ones");
    p_cmp_bool_r6: assert (!(op == OP_SLT || op == OP_SLTI) || result[DW-1:1] == '0)
      else $error("compare result not boolean");
    p_upper_low_zero_r8: assert (op != OP_LUI || result[HALF-1:0] == '0)
      else $error("upper load left low bits set");
  end
endmodule

// File: tb/exec_unit_tb.sv
module exec_unit_tb;
  localparam int DW = 64;
  localparam logic [DW-1:0] ONES = '1;

  typedef struct {
    string         tag;
    logic [DW-1:0] res;
    logic          we;
    logic          dz;
    logic          bad;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    op = 8'h00;
  logic [DW-1:0] src_a = '0, src_b = '0, imm = '0;
  logic [DW-1:0] result;
  logic          wr_en, div_zero, bad_op;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;
  exp_t          q[$];
  exp_t          cur;

  always #10 clk = ~clk;

  exec_unit #(.DW(DW)) u_dut (
    .op(op), .src_a(src_a), .src_b(src_b), .imm(imm),
    .result(result), .wr_en(wr_en), .div_zero(div_zero), .bad_op(bad_op)
  );

  task automatic drive(input string tag, input logic [7:0] o,
                       input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [DW-1:0] i, input logic [DW-1:0] r,
                       input logic we, input logic dz, input logic bad);
    exp_t e;
    @(posedge clk);
    #1;
    op = o; src_a = a; src_b = b; imm = i;
    e.tag = tag; e.res = r; e.we = we; e.dz = dz; e.bad = bad;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (result !== cur.res || wr_en !== cur.we || div_zero !== cur.dz || bad_op !== cur.bad) begin
        errors++;
        $display("FAIL %s: got res=%h we=%b dz=%b bad=%b, expected res=%h we=%b dz=%b bad=%b",
                 cur.tag, result, wr_en, div_zero, bad_op, cur.res, cur.we, cur.dz, cur.bad);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs decode as NOP (R9)
    drive("R9 reset idle", 8'h00, 0, 0, 0, 0, 0, 0, 0);
    // R1
    drive("R1 add", 8'h10, 5, 7, 0, 12, 1, 0, 0);
    drive("R1 add wrap", 8'h10, ONES, 1, 0, 0, 1, 0, 0);
    drive("R1 addi neg imm", 8'h11, 10, 99, -64'sd3, 7, 1, 0, 0);
    drive("R1 sub", 8'h12, 3, 5, 0, 64'hFFFF_FFFF_FFFF_FFFE, 1, 0, 0);
    // R2
    drive("R2 mult low half", 8'h13, 64'h1_0000_0000, 64'h1_0000_0003, 0,
          64'h0000_0003_0000_0000, 1, 0, 0);
    drive("R2 mult signed", 8'h13, -64'sd2, 3, 0, 64'hFFFF_FFFF_FFFF_FFFA, 1, 0, 0);
    // R3
    drive("R3 div", 8'h14, 100, 7, 0, 14, 1, 0, 0);
    drive("R3 div neg trunc", 8'h14, -64'sd7, 2, 0, 64'hFFFF_FFFF_FFFF_FFFD, 1, 0, 0);
    drive("R3 mod", 8'h15, 100, 7, 0, 2, 1, 0, 0);
    drive("R3 mod neg", 8'h15, -64'sd7, 2, 0, ONES, 1, 0, 0);
    drive("R3 div overflow", 8'h14, 64'h8000_0000_0000_0000, ONES, 0,
          64'h8000_0000_0000_0000, 1, 0, 0);
    drive("R3 mod overflow", 8'h15, 64'h8000_0000_0000_0000, ONES, 0, 0, 1, 0, 0);
    // R4
    drive("R4 div by zero", 8'h14, 42, 0, 0, ONES, 1, 1, 0);
    drive("R4 mod by zero", 8'h15, 42, 0, 0, 42, 1, 1, 0);
    drive("R4 no flag on add", 8'h10, 42, 0, 0, 42, 1, 0, 0);
    // R5
    drive("R5 and", 8'h30, 64'hF0F0, 64'hFF00, 0, 64'hF000, 1, 0, 0);
    drive("R5 andi", 8'h31, 64'hFF, 64'h0, 64'h0F, 64'h0F, 1, 0, 0);
    drive("R5 or", 8'h32, 64'hF0, 64'h0F, 0, 64'hFF, 1, 0, 0);
    drive("R5 ori", 8'h33, 64'h100, 64'h0, 64'h1, 64'h101, 1, 0, 0);
    drive("R5 xor", 8'h34, 64'hFF, 64'h0F, 0, 64'hF0, 1, 0, 0);
    drive("R5 nor zeros", 8'h35, 0, 0, 0, ONES, 1, 0, 0);
    drive("R5 nor halves", 8'h35, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 0, 0, 1, 0, 0);
    // R6
    drive("R6 slt neg<pos", 8'h36, ONES, 1, 0, 1, 1, 0, 0);
    drive("R6 slt pos<neg", 8'h36, 1, ONES, 0, 0, 1, 0, 0);
    drive("R6 slt equal", 8'h36, 5, 5, 0, 0, 1, 0, 0);
    drive("R6 slti true", 8'h37, 3, 0, 4, 1, 1, 0, 0);
    drive("R6 slti neg false", 8'h37, -64'sd5, 0, -64'sd6, 0, 1, 0, 0);
    // R7
    drive("R7 slli 63", 8'h40, 1, 0, 63, 64'h8000_0000_0000_0000, 1, 0, 0);
    drive("R7 slli 64 masks", 8'h40, 1, 0, 64, 1, 1, 0, 0);
    drive("R7 srli logical", 8'h41, ONES, 0, 60, 64'hF, 1, 0, 0);
    drive("R7 sll reg", 8'h42, 3, 4, 0, 64'h30, 1, 0, 0);
    drive("R7 srl zero fill", 8'h43, 64'h8000_0000_0000_0000, 63, 0, 1, 1, 0, 0);
    drive("R7 srl masks amount", 8'h43, 64'h10, 64'h41, 0, 8, 1, 0, 0);
    // R8
    drive("R8 lui", 8'h22, 7, 7, 64'h1234, 64'h0000_1234_0000_0000, 1, 0, 0);
    drive("R8 lui neg", 8'h22, 0, 0, ONES, 64'hFFFF_FFFF_0000_0000, 1, 0, 0);
    // R9
    drive("R9 nop busy operands", 8'h00, 64'h55, 64'hAA, 64'h3, 0, 0, 0, 0);
    // R10
    drive("R10 op 01", 8'h01, 1, 2, 3, 0, 0, 0, 1);
    drive("R10 op 20", 8'h20, 1, 2, 3, 0, 0, 0, 1);
    drive("R10 op 16 zero b", 8'h16, 1, 0, 3, 0, 0, 0, 1);
    drive("R10 op 44", 8'h44, 1, 2, 3, 0, 0, 0, 1);
    drive("R10 op FF", 8'hFF, ONES, ONES, ONES, 0, 0, 0, 1);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule